// File: doc/BRIEF.md
# Reservation Station Bank With Tag Broadcast

This block holds a small pool of reservation stations and the per-register table that records which station will produce each architectural register. An instruction arrives with an operation code, a destination register, two source registers, an address field, and the two register-file values for its sources. Each source then resolves to one of two things: a captured value, or the tag of the station that will produce it. A source with a zero tag is complete. No separate ready flag exists.

The block watches a single result bus that carries a 4-bit producer tag and 64 bits of data. A broadcast does three things. Every waiting source that holds that tag takes the data. The station that owns the tag becomes free again. Any register whose pending writer is that tag is marked as having no pending writer.

When both tags of a busy entry are zero, the entry goes once to the functional unit. Stations carry tags 1 to NUM_RS. Tag 0 means "no producer" and never matches a broadcast.

Top module: `rsb_bank`

## Requirements
- R1: After reset every station is free. `iss_ready` is 1, `iss_tag` is 1, `disp_valid` is 0, and no register has a pending writer.
- R2: An issue picks the lowest-index free station and reports its tag (index+1) on `iss_tag` in the same cycle. When no station is free, `iss_ready` is 0 and `iss_tag` is 0. An `iss_valid` then changes no state.
- R3: A source whose register has no pending writer captures `iss_val1`/`iss_val2` as its operand value.
- R4: A source whose register has a pending writer captures that writer's tag. The entry is not dispatched while either tag is nonzero.
- R5: A broadcast with a nonzero tag writes `cdb_data` into every busy entry's source that holds the tag, and clears that tag. The entry can dispatch in the next cycle.
- R6: If the producer of a source broadcasts in the cycle the consumer issues, the source captures `cdb_data` directly and holds no tag.
- R7: A broadcast frees the station whose tag matches. It also clears every register status equal to the tag, so a later read of that register takes the register-file value.
- R8: Dispatch shows, registered, the lowest-index busy entry whose tags are both zero and which has not yet been dispatched. An entry is dispatched at most once per issue, in the cycle after it becomes ready.
- R9: A broadcast carrying tag 0 has no effect on operands, stations or register status.
- R10: Issue sets the destination register's status to the new tag, replacing any older writer. A later broadcast of the older tag leaves the newer status in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | REG_AW | Destination register |
| iss_src1 | input | REG_AW | First source register |
| iss_src2 | input | REG_AW | Second source register |
| iss_addr | input | ADDR_W | Address field kept with the entry |
| iss_val1 | input | DATA_W | Register-file value of the first source |
| iss_val2 | input | DATA_W | Register-file value of the second source |
| iss_ready | output | 1 | A free station exists |
| iss_tag | output | 4 | Tag the next issue receives, 0 when full |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Producer tag of the broadcast |
| cdb_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | An entry is sent to the functional unit |
| disp_tag | output | 4 | Tag of the dispatched entry |
| disp_op | output | OP_W | Its operation code |
| disp_vj | output | DATA_W | Its first operand |
| disp_vk | output | DATA_W | Its second operand |
| disp_addr | output | ADDR_W | Its address field |

## Verification
The bench issues a consumer in the same cycle as its producer's broadcast. A design that latched the stale tag would leave that entry waiting forever. It also sends a broadcast with tag 0 while an entry holds one ready and one waiting operand. A design that treated zero as a match would overwrite the ready operand or free something.

It fills every station and offers one more instruction. It then wakes three entries at once. This exposes an accepted overflow, an out-of-order dispatch, or a repeated dispatch. Finally, two writers to one register followed by the older writer's broadcast show whether register status is wrongly cleared, which would let a later reader take a stale register-file value.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    // The result bus tag width is fixed; station tags run 1 .. 15 at most.
    localparam int unsigned TAG_W   = 4;
    localparam int unsigned TAG_MAX = (1 << TAG_W) - 1;

    typedef logic [TAG_W-1:0] rsb_tag_t;

    // True when a live broadcast names the given producer tag (tag 0 never hits).
    function automatic logic bus_hits(input logic bvalid, input rsb_tag_t btag,
                                      input rsb_tag_t q);
        return bvalid && (btag != '0) && (btag == q);
    endfunction
endpackage

// File: rtl/rsb_lowest_pick.sv
module rsb_lowest_pick #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rsb_src_resolve.sv
module rsb_src_resolve
    import rsb_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  rsb_tag_t          stat_tag,
    input  logic [DATA_W-1:0] rf_val,
    input  logic              bus_valid,
    input  rsb_tag_t          bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] val,
    output rsb_tag_t          q
);
    always_comb begin
        if (stat_tag == '0) begin
            val = rf_val;
            q   = '0;
        end else if (bus_hits(bus_valid, bus_tag, stat_tag)) begin
            val = bus_data;
            q   = '0;
        end else begin
            val = '0;
            q   = stat_tag;
        end
    end
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
    import rsb_pkg::*;
#(
    parameter int unsigned NUM_RS   = 4,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned OP_W     = 3,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 64,
    localparam int unsigned REG_AW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int unsigned IDX_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [REG_AW-1:0] iss_src1,
    input  logic [REG_AW-1:0] iss_src2,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [DATA_W-1:0] iss_val1,
    input  logic [DATA_W-1:0] iss_val2,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [ADDR_W-1:0] disp_addr
);
    // NUM_RS must not exceed TAG_MAX: station i owns tag i+1, tag 0 is "none".

    typedef struct packed {
        logic              busy;
        logic              sent;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [DATA_W-1:0] vk;
        rsb_tag_t          qj;
        rsb_tag_t          qk;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    typedef struct packed {
        entry_t   [NUM_RS-1:0]   ent;
        rsb_tag_t [NUM_REGS-1:0] stat;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_RS-1:0] free_req, rdy_req;
    logic              free_found, rdy_found;
    logic [IDX_W-1:0]  free_idx, rdy_idx;

    always_comb begin
        for (int i = 0; i < NUM_RS; i++) begin
            free_req[i] = !st_q.ent[i].busy;
            rdy_req[i]  = st_q.ent[i].busy && !st_q.ent[i].sent &&
                          (st_q.ent[i].qj == '0) && (st_q.ent[i].qk == '0);
        end
    end

    rsb_lowest_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_free_pick (
        .req(free_req), .found(free_found), .idx(free_idx)
    );

    rsb_lowest_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_rdy_pick (
        .req(rdy_req), .found(rdy_found), .idx(rdy_idx)
    );

    // Source operand resolution, one resolver per source.
    logic [1:0][REG_AW-1:0] src_reg;
    logic [1:0][DATA_W-1:0] src_rf;
    logic [1:0][DATA_W-1:0] src_val;
    rsb_tag_t [1:0]         src_q;

    assign src_reg = {iss_src2, iss_src1};
    assign src_rf  = {iss_val2, iss_val1};

    for (genvar s = 0; s < 2; s++) begin : g_src
        rsb_src_resolve #(.DATA_W(DATA_W)) u_res (
            .stat_tag (st_q.stat[src_reg[s]]),
            .rf_val   (src_rf[s]),
            .bus_valid(cdb_valid),
            .bus_tag  (cdb_tag),
            .bus_data (cdb_data),
            .val      (src_val[s]),
            .q        (src_q[s])
        );
    end

    always_comb begin
        st_d = st_q;

        // Dispatch: mark the chosen entry as sent.
        if (rdy_found) begin
            st_d.ent[rdy_idx].sent = 1'b1;
        end

        // Broadcast: wake waiting sources and free the producing station.
        for (int i = 0; i < NUM_RS; i++) begin
            if (st_q.ent[i].busy) begin
                if (bus_hits(cdb_valid, cdb_tag, st_q.ent[i].qj)) begin
                    st_d.ent[i].vj = cdb_data;
                    st_d.ent[i].qj = '0;
                end
                if (bus_hits(cdb_valid, cdb_tag, st_q.ent[i].qk)) begin
                    st_d.ent[i].vk = cdb_data;
                    st_d.ent[i].qk = '0;
                end
                if (bus_hits(cdb_valid, cdb_tag, rsb_tag_t'(i + 1))) begin
                    st_d.ent[i].busy = 1'b0;
                    st_d.ent[i].sent = 1'b0;
                end
            end
        end

        // Broadcast: retire register status that names the tag.
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_hits(cdb_valid, cdb_tag, st_q.stat[r])) begin
                st_d.stat[r] = '0;
            end
        end

        // Issue: fill the lowest free station, rename the destination.
        if (iss_valid && free_found) begin
            st_d.ent[free_idx].busy = 1'b1;
            st_d.ent[free_idx].sent = 1'b0;
            st_d.ent[free_idx].op   = iss_op;
            st_d.ent[free_idx].vj   = src_val[0];
            st_d.ent[free_idx].vk   = src_val[1];
            st_d.ent[free_idx].qj   = src_q[0];
            st_d.ent[free_idx].qk   = src_q[1];
            st_d.ent[free_idx].addr = iss_addr;
            st_d.stat[iss_dst]      = rsb_tag_t'(free_idx) + rsb_tag_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_ready  = free_found;
    assign iss_tag    = free_found ? (rsb_tag_t'(free_idx) + rsb_tag_t'(1)) : '0;
    assign disp_valid = rdy_found;
    assign disp_tag   = rdy_found ? (rsb_tag_t'(rdy_idx) + rsb_tag_t'(1)) : '0;
    assign disp_op    = st_q.ent[rdy_idx].op;
    assign disp_vj    = st_q.ent[rdy_idx].vj;
    assign disp_vk    = st_q.ent[rdy_idx].vk;
    assign disp_addr  = st_q.ent[rdy_idx].addr;
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk
    import rsb_pkg::*;
#(
    parameter int unsigned NUM_RS = 4
) (
    input logic     clk,
    input logic     rst_n,
    input logic     iss_valid,
    input logic     iss_ready,
    input rsb_tag_t iss_tag,
    input logic     cdb_valid,
    input rsb_tag_t cdb_tag,
    input logic     disp_valid,
    input rsb_tag_t disp_tag
);
    // R2: an offered tag always names a real station; a full bank offers none.
    assert_iss_tag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> (iss_tag != '0) && (iss_tag <= rsb_tag_t'(NUM_RS)));

    assert_full_no_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (iss_tag == '0));

    // R2: the station just taken is not offered again next cycle.
    assert_issue_consumes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !(cdb_valid && cdb_tag == iss_tag))
        |=> (!iss_ready || iss_tag != $past(iss_tag)));

    // R8: dispatched tags are real stations and never repeat back to back.
    assert_disp_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag != '0) && (disp_tag <= rsb_tag_t'(NUM_RS)));

    assert_no_redispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));

    // R7: a station whose tag was broadcast is free next cycle, so not dispatched.
    assert_freed_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && cdb_tag != '0) |=> !(disp_valid && disp_tag == $past(cdb_tag)));
endmodule

bind rsb_bank rsb_bank_chk #(.NUM_RS(NUM_RS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_tag   (iss_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .disp_valid(disp_valid),
    .disp_tag  (disp_tag)
);

// File: tb/rsb_bank_test.sv
module rsb_bank_test;
    localparam int unsigned DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [2:0]        iss_op = '0;
    logic [2:0]        iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [15:0]       iss_addr = '0;
    logic [DATA_W-1:0] iss_val1 = '0, iss_val2 = '0;
    logic              iss_ready;
    logic [3:0]        iss_tag;
    logic              cdb_valid = 1'b0;
    logic [3:0]        cdb_tag = '0;
    logic [DATA_W-1:0] cdb_data = '0;
    logic              disp_valid;
    logic [3:0]        disp_tag;
    logic [2:0]        disp_op;
    logic [DATA_W-1:0] disp_vj, disp_vk;
    logic [15:0]       disp_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsb_bank uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_addr(iss_addr),
        .iss_val1(iss_val1), .iss_val2(iss_val2),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_addr(disp_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one clock; inputs set before the call apply at that edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic set_iss(input logic [2:0] op, input logic [2:0] dst,
                           input logic [2:0] s1, input logic [2:0] s2,
                           input logic [63:0] v1, input logic [63:0] v2);
        iss_valid = 1'b1; iss_op = op; iss_dst = dst;
        iss_src1 = s1; iss_src2 = s2; iss_val1 = v1; iss_val2 = v2;
        iss_addr = {13'd0, op} + 16'h100;
    endtask

    task automatic set_bus(input logic [3:0] t, input logic [63:0] d);
        cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    endtask

    task automatic free_tag(input logic [3:0] t);
        set_bus(t, 64'h0);
        step();
    endtask

    task automatic t_reset();
        chk("R1", "iss_ready", iss_ready, 1);
        chk("R1", "iss_tag", iss_tag, 1);
        chk("R1", "disp_valid", disp_valid, 0);
    endtask

    task automatic t_ready_operands();
        set_iss(3'd2, 3'd1, 3'd2, 3'd3, 64'd10, 64'd20);
        chk("R2", "tag offered", iss_tag, 1);
        step();
        chk("R3", "disp_valid", disp_valid, 1);
        chk("R3", "disp_tag", disp_tag, 1);
        chk("R3", "vj", disp_vj, 10);
        chk("R3", "vk", disp_vk, 20);
        chk("R3", "op", disp_op, 2);
        chk("R3", "addr", disp_addr, 16'h102);
        chk("R2", "next tag", iss_tag, 2);
        step();
        chk("R8", "single dispatch", disp_valid, 0);
        set_bus(4'd1, 64'd30);
        step();
        chk("R7", "station freed", iss_tag, 1);
        // r1 status cleared: reader takes register-file value
        set_iss(3'd1, 3'd0, 3'd1, 3'd1, 64'd77, 64'd78);
        step();
        chk("R7", "status cleared disp", disp_valid, 1);
        chk("R7", "status cleared vj", disp_vj, 77);
        free_tag(4'd1);
    endtask

    task automatic t_tag_wait();
        set_iss(3'd3, 3'd4, 3'd0, 3'd0, 64'd1, 64'd1);
        step();
        chk("R8", "producer dispatch", disp_tag, 1);
        set_iss(3'd4, 3'd5, 3'd4, 3'd1, 64'hBAD, 64'd9);
        chk("R2", "consumer tag", iss_tag, 2);
        step();
        chk("R4", "waiting not dispatched", disp_valid, 0);
        step();
        chk("R4", "still waiting", disp_valid, 0);
        set_bus(4'd1, 64'h55);
        step();
        chk("R5", "woken disp", disp_valid, 1);
        chk("R5", "woken tag", disp_tag, 2);
        chk("R5", "woken vj", disp_vj, 64'h55);
        chk("R5", "kept vk", disp_vk, 9);
        free_tag(4'd2);
    endtask

    task automatic t_bypass();
        set_iss(3'd1, 3'd6, 3'd0, 3'd0, 64'd3, 64'd4);
        step();
        chk("R8", "producer dispatch", disp_tag, 1);
        set_iss(3'd5, 3'd2, 3'd6, 3'd0, 64'hBAD, 64'd8);
        set_bus(4'd1, 64'h99);
        chk("R6", "consumer tag", iss_tag, 2);
        step();
        chk("R6", "bypass disp", disp_valid, 1);
        chk("R6", "bypass tag", disp_tag, 2);
        chk("R6", "bypass vj", disp_vj, 64'h99);
        free_tag(4'd2);
    endtask

    task automatic t_full();
        set_iss(3'd1, 3'd7, 3'd0, 3'd0, 64'd1, 64'd2);
        step();
        set_iss(3'd2, 3'd6, 3'd7, 3'd0, 64'd0, 64'd12);
        step();
        set_iss(3'd3, 3'd5, 3'd7, 3'd0, 64'd0, 64'd13);
        step();
        set_iss(3'd4, 3'd4, 3'd7, 3'd0, 64'd0, 64'd14);
        step();
        chk("R2", "full ready", iss_ready, 0);
        chk("R2", "full tag", iss_tag, 0);
        // offered while full: would be ready at once if accepted
        set_iss(3'd6, 3'd1, 3'd0, 3'd0, 64'd5, 64'd6);
        step();
        chk("R2", "ignored issue no disp", disp_valid, 0);
        chk("R2", "still full", iss_ready, 0);
        set_bus(4'd1, 64'hAB);
        step();
        chk("R7", "slot one freed", iss_tag, 1);
        chk("R8", "first of three", disp_tag, 2);
        chk("R5", "first of three vj", disp_vj, 64'hAB);
        chk("R8", "first of three vk", disp_vk, 12);
        step();
        chk("R8", "second of three", disp_tag, 3);
        step();
        chk("R8", "third of three", disp_tag, 4);
        chk("R8", "third of three vk", disp_vk, 14);
        step();
        chk("R8", "none left", disp_valid, 0);
        free_tag(4'd2);
        free_tag(4'd3);
        free_tag(4'd4);
        // r1 untouched by the ignored issue
        set_iss(3'd0, 3'd0, 3'd1, 3'd0, 64'h33, 64'd0);
        step();
        chk("R2", "ignored issue left status", disp_vj, 64'h33);
        chk("R2", "ignored issue disp", disp_valid, 1);
        free_tag(4'd1);
        chk("R2", "all free", iss_tag, 1);
    endtask

    task automatic t_zero_tag();
        set_iss(3'd1, 3'd2, 3'd0, 3'd0, 64'd1, 64'd1);
        step();
        set_iss(3'd2, 3'd3, 3'd2, 3'd0, 64'hBAD, 64'h11);
        step();
        set_bus(4'd0, 64'hDEAD);
        step();
        chk("R9", "no wake on tag 0", disp_valid, 0);
        chk("R9", "nothing freed", iss_tag, 3);
        set_iss(3'd3, 3'd4, 3'd2, 3'd0, 64'hBAD, 64'd0);
        step();
        chk("R9", "status kept", disp_valid, 0);
        set_bus(4'd1, 64'h22);
        step();
        chk("R9", "wake after tag 1", disp_tag, 2);
        chk("R9", "vj", disp_vj, 64'h22);
        chk("R9", "vk not overwritten", disp_vk, 64'h11);
        step();
        chk("R5", "second waiter", disp_tag, 3);
        chk("R5", "second waiter vj", disp_vj, 64'h22);
        free_tag(4'd2);
        free_tag(4'd3);
    endtask

    task automatic t_waw();
        set_iss(3'd1, 3'd3, 3'd0, 3'd0, 64'd1, 64'd1);
        step();
        set_iss(3'd2, 3'd3, 3'd0, 3'd0, 64'd2, 64'd2);
        step();
        chk("R10", "second writer dispatched", disp_tag, 2);
        set_bus(4'd1, 64'h77);
        step();
        set_iss(3'd3, 3'd0, 3'd3, 3'd0, 64'hBAD, 64'd0);
        chk("R10", "reader tag", iss_tag, 1);
        step();
        chk("R10", "reader waits on newer", disp_valid, 0);
        set_bus(4'd2, 64'h42);
        step();
        chk("R10", "reader woken", disp_tag, 1);
        chk("R10", "reader vj", disp_vj, 64'h42);
        free_tag(4'd1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ready_operands();
        t_tag_wait();
        t_bypass();
        t_full();
        t_zero_tag();
        t_waw();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule